// File: doc/BRIEF.md
# Flash Toggle-Bit Status Responder

This block sits on the read path of a parallel NOR flash array. It decides what a read cycle returns while an embedded program or erase operation is running. The command decoder pulses a completion strobe once the last write of a program or erase command has been accepted. From the clock edge after that strobe, every read returns a status byte instead of array contents. In that byte, bit 6 inverts on each read cycle, so a host that reads twice in a row can tell whether the device is still working. Bit 5 reports that the operation has timed out.

The length of the busy period is chosen when the operation starts. A normal operation lasts for the number of cycles given on the busy-length input; this covers an erase whose selected sectors are only partly protected. If the whole target is protected, the device still looks busy for a fixed interval before it returns to array reads. That interval is long for an erase and short for a program, and nothing is changed in the array. A host that sees the timeout flag must issue the reset command to leave the status mode.

Top module: `flash_toggle_status`

## Requirements
- R1: After synchronous reset the block is idle: `busy` is 0, `rd_data` equals `array_data`, and the toggle bit is 0 for the first status word of the next operation.
- R2: A `cmd_done` pulse while idle makes `busy` 1 from the next cycle. While busy, `rd_data` is a status word: bit 6 is the toggle bit, bit 5 is the timeout flag, and bits 7 and 4..0 are 0.
- R3: While busy, each cycle with `rd_oe` or `rd_ce` high counts as one read and inverts bit 6 from the next cycle on. Both strobes high in the same cycle count as a single read. A cycle with no read strobe leaves bit 6 unchanged.
- R4: With `tgt_prot` low, the operation stays busy for exactly `busy_len` cycles, or 1 cycle when `busy_len` is 0, for either a program or an erase. After that, `rd_data` returns `array_data`.
- R5: An erase (`op_erase`=1) with `tgt_prot` high stays busy for PROT_ERASE_CYC cycles, whatever the value of `busy_len`.
- R6: A program (`op_erase`=0) with `tgt_prot` high stays busy for PROT_PROG_CYC cycles, whatever the value of `busy_len`.
- R7: Read strobes while idle do not change the toggle bit. The toggle bit keeps its value from one operation to the next unless it is reset.
- R8: A `cmd_done` pulse while busy is ignored: the end time and the status word of the running operation do not change.
- R9: `tmo_inject` high while busy sets bit 5 from the next cycle. The block then stays busy, with bit 6 still toggling on reads, until `rst_cmd`.
- R10: `rst_cmd` makes the block idle from the next cycle and clears the toggle bit and the timeout flag. `tmo_inject` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_done | input | 1 | One-cycle strobe: a program or erase command sequence is complete |
| op_erase | input | 1 | Operation type sampled with `cmd_done`: 1 erase, 0 program |
| tgt_prot | input | 1 | Sampled with `cmd_done`: the whole target is protected |
| busy_len | input | LEN_W | Busy duration in cycles for an unprotected target |
| rd_oe | input | 1 | Read cycle framed by output enable |
| rd_ce | input | 1 | Read cycle framed by chip enable |
| tmo_inject | input | 1 | Forces the timeout condition on a running operation |
| rst_cmd | input | 1 | Reset-command strobe that aborts status mode |
| array_data | input | 8 | Data from the cell array |
| rd_data | output | 8 | Byte returned on the read path |
| busy | output | 1 | An operation or protected-target interval is in progress |

## Verification
The hardest situations to reach are the collisions at the edges of an interval. Examples are a read strobe, a second `cmd_done` or a `tmo_inject` arriving in the last busy cycle, and a `rst_cmd` arriving together with a new command. Directed tasks time a strobe to a chosen busy cycle to cover these cases. A long random phase then uses short busy lengths and shortened protected intervals, so these coincidences happen many times. A behavioural model in the bench checks every cycle of that phase.

// File: rtl/flash_tgl_pkg.sv
package flash_tgl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RUN  = 2'd1,
        OP_HUNG = 2'd2
    } op_state_e;

    typedef struct packed {
        logic       rsv_hi;
        logic       toggle;
        logic       timeout;
        logic [4:0] rsv_lo;
    } status_t;

    function automatic logic [7:0] pack_status(input logic tog, input logic tmo);
        status_t s;
        s         = '0;
        s.toggle  = tog;
        s.timeout = tmo;
        return s;
    endfunction

    function automatic int cnt_width(input int a, input int b, input int lw);
        int m;
        m = (a > b) ? a : b;
        if (lw >= 31) return 32;
        if ((1 << lw) > m) m = 1 << lw;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/tgl_op_timer.sv
module tgl_op_timer
    import flash_tgl_pkg::*;
#(
    parameter int LEN_W          = 16,
    parameter int CNT_W          = 24,
    parameter int PROT_ERASE_CYC = 12_500_000,
    parameter int PROT_PROG_CYC  = 250_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_cmd,
    input  logic             cmd_done,
    input  logic             op_erase,
    input  logic             tgt_prot,
    input  logic [LEN_W-1:0] busy_len,
    input  logic             tmo_inject,
    output op_state_e        state
);
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        if (tgt_prot)
            load_val = op_erase ? CNT_W'(PROT_ERASE_CYC) : CNT_W'(PROT_PROG_CYC);
        else if (busy_len == '0)
            load_val = CNT_W'(1);
        else
            load_val = CNT_W'(busy_len);
    end

    always_ff @(posedge clk) begin
        if (rst || rst_cmd) begin
            state  <= OP_IDLE;
            remain <= '0;
        end else begin
            unique case (state)
                OP_IDLE: begin
                    if (cmd_done) begin
                        state  <= OP_RUN;
                        remain <= load_val;
                    end
                end
                OP_RUN: begin
                    if (tmo_inject)
                        state <= OP_HUNG;
                    else if (remain <= CNT_W'(1))
                        state <= OP_IDLE;
                    else
                        remain <= remain - CNT_W'(1);
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/tgl_toggle_reg.sv
module tgl_toggle_reg (
    input  logic clk,
    input  logic rst,
    input  logic rst_cmd,
    input  logic active,
    input  logic rd_oe,
    input  logic rd_ce,
    output logic tog
);
    logic rd_cycle;
    assign rd_cycle = rd_oe | rd_ce;

    always_ff @(posedge clk) begin
        if (rst || rst_cmd)
            tog <= 1'b0;
        else if (active && rd_cycle)
            tog <= ~tog;
    end
endmodule

// File: rtl/tgl_status_mux.sv
module tgl_status_mux
    import flash_tgl_pkg::*;
(
    input  op_state_e  state,
    input  logic       tog,
    input  logic [7:0] array_data,
    output logic [7:0] rd_data,
    output logic       busy
);
    always_comb begin
        busy    = (state != OP_IDLE);
        rd_data = busy ? pack_status(tog, state == OP_HUNG) : array_data;
    end
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
    import flash_tgl_pkg::*;
#(
    parameter int LEN_W          = 16,
    parameter int PROT_ERASE_CYC = 12_500_000,
    parameter int PROT_PROG_CYC  = 250_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_done,
    input  logic             op_erase,
    input  logic             tgt_prot,
    input  logic [LEN_W-1:0] busy_len,
    input  logic             rd_oe,
    input  logic             rd_ce,
    input  logic             tmo_inject,
    input  logic             rst_cmd,
    input  logic [7:0]       array_data,
    output logic [7:0]       rd_data,
    output logic             busy
);
    localparam int CNT_W = cnt_width(PROT_ERASE_CYC, PROT_PROG_CYC, LEN_W);

    op_state_e state;
    logic      tog;

    tgl_op_timer #(
        .LEN_W         (LEN_W),
        .CNT_W         (CNT_W),
        .PROT_ERASE_CYC(PROT_ERASE_CYC),
        .PROT_PROG_CYC (PROT_PROG_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .rst_cmd   (rst_cmd),
        .cmd_done  (cmd_done),
        .op_erase  (op_erase),
        .tgt_prot  (tgt_prot),
        .busy_len  (busy_len),
        .tmo_inject(tmo_inject),
        .state     (state)
    );

    tgl_toggle_reg u_tog (
        .clk    (clk),
        .rst    (rst),
        .rst_cmd(rst_cmd),
        .active (state != OP_IDLE),
        .rd_oe  (rd_oe),
        .rd_ce  (rd_ce),
        .tog    (tog)
    );

    tgl_status_mux u_mux (
        .state     (state),
        .tog       (tog),
        .array_data(array_data),
        .rd_data   (rd_data),
        .busy      (busy)
    );
endmodule

// File: rtl/flash_toggle_status_chk.sv
module flash_toggle_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_done,
    input logic       rd_oe,
    input logic       rd_ce,
    input logic       rst_cmd,
    input logic [7:0] array_data,
    input logic [7:0] rd_data,
    input logic       busy
);
    // R1
    idle_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> rd_data == array_data);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_done && !rst_cmd) |=> busy);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_data[7] == 1'b0 && rd_data[4:0] == 5'd0));

    // R3
    read_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (rd_oe || rd_ce)) |=> (!busy || rd_data[6] != $past(rd_data[6])));

    // R3
    no_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_oe && !rd_ce) |=> (!busy || rd_data[6] == $past(rd_data[6])));

    // R9
    hung_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_data[5] && !rst_cmd) |=> (busy && rd_data[5]));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> !busy);
endmodule

bind flash_toggle_status flash_toggle_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_done  (cmd_done),
    .rd_oe     (rd_oe),
    .rd_ce     (rd_ce),
    .rst_cmd   (rst_cmd),
    .array_data(array_data),
    .rd_data   (rd_data),
    .busy      (busy)
);

// File: tb/sim_flash_toggle_status.sv
`timescale 1ns/1ps
module sim_flash_toggle_status;
    localparam int LEN_W = 8;
    localparam int P_ER  = 60;
    localparam int P_PG  = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_done = 1'b0;
    logic             op_erase = 1'b0;
    logic             tgt_prot = 1'b0;
    logic [LEN_W-1:0] busy_len = '0;
    logic             rd_oe = 1'b0;
    logic             rd_ce = 1'b0;
    logic             tmo_inject = 1'b0;
    logic             rst_cmd = 1'b0;
    logic [7:0]       array_data = 8'h00;
    logic [7:0]       rd_data;
    logic             busy;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // behavioural reference: 0 idle, 1 running, 2 timed out
    int m_state = 0;
    int m_rem   = 0;
    bit m_tog   = 1'b0;

    always #4 clk = ~clk;

    flash_toggle_status #(
        .LEN_W(LEN_W), .PROT_ERASE_CYC(P_ER), .PROT_PROG_CYC(P_PG)
    ) u0 (
        .clk(clk), .rst(rst), .cmd_done(cmd_done), .op_erase(op_erase),
        .tgt_prot(tgt_prot), .busy_len(busy_len), .rd_oe(rd_oe), .rd_ce(rd_ce),
        .tmo_inject(tmo_inject), .rst_cmd(rst_cmd), .array_data(array_data),
        .rd_data(rd_data), .busy(busy)
    );

    always @(posedge clk) begin
        if (rst || rst_cmd) begin
            m_state = 0; m_rem = 0; m_tog = 1'b0;
        end else begin
            if (m_state != 0 && (rd_oe || rd_ce)) m_tog = !m_tog;
            if (m_state == 0) begin
                if (cmd_done) begin
                    m_state = 1;
                    if (tgt_prot) m_rem = op_erase ? P_ER : P_PG;
                    else m_rem = (busy_len == 0) ? 1 : int'(busy_len);
                end
            end else if (m_state == 1) begin
                if (tmo_inject) m_state = 2;
                else if (m_rem == 1) m_state = 0;
                else m_rem = m_rem - 1;
            end
        end
    end

    function automatic logic [7:0] model_out();
        if (m_state == 0) return array_data;
        return {1'b0, m_tog, (m_state == 2), 5'b0};
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (cmp_on && !rst) begin
            check((m_state == 0) ? "R4 idle data" : "R3 status word", rd_data, model_out());
            check("R2 busy flag", busy, (m_state != 0));
        end
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    always @(negedge clk) #2 array_data = 8'($urandom);

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic run_op(input bit er, input bit pr, input int len, input bit rd_en,
                          input int dup_at, output int cyc);
        step();
        op_erase = er; tgt_prot = pr; busy_len = LEN_W'(len); cmd_done = 1'b1;
        step();
        cmd_done = 1'b0;
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            rd_oe = rd_en ? 1'($urandom) : 1'b0;
            if (cyc == dup_at) begin
                cmd_done = 1'b1; tgt_prot = 1'b1; op_erase = 1'b1;
            end else cmd_done = 1'b0;
            step();
        end
        rd_oe = 1'b0; cmd_done = 1'b0;
    endtask

    initial begin
        int c;
        bit b0;
        bit saved;
        repeat (3) step();
        rst = 1'b0;
        cmp_on = 1'b1;
        step();
        check("R1 reset busy", busy, 0);
        check("R1 reset passthrough", rd_data, array_data);

        // first status word after reset shows toggle 0
        step();
        busy_len = 8'd6; tgt_prot = 1'b0; cmd_done = 1'b1;
        step();
        cmd_done = 1'b0;
        check("R2 busy next cycle", busy, 1);
        check("R1 toggle cleared", rd_data[6], 0);
        check("R2 reserved bits", {rd_data[7], rd_data[4:0]}, 0);
        while (busy) step();

        run_op(1'b0, 1'b0, 5, 1'b1, -1, c);  check("R4 program length", c, 5);
        run_op(1'b1, 1'b0, 9, 1'b1, -1, c);  check("R4 erase length", c, 9);
        run_op(1'b1, 1'b0, 0, 1'b0, -1, c);  check("R4 zero length", c, 1);
        check("R4 array after done", rd_data, array_data);
        run_op(1'b1, 1'b1, 3, 1'b1, -1, c);  check("R5 protected erase", c, P_ER);
        run_op(1'b0, 1'b1, 200, 1'b1, -1, c); check("R6 protected program", c, P_PG);
        run_op(1'b0, 1'b0, 12, 1'b1, 4, c);  check("R8 cmd while busy", c, 12);

        // R3: strobe handling
        step();
        busy_len = 8'd20; tgt_prot = 1'b0; cmd_done = 1'b1;
        step();
        cmd_done = 1'b0;
        b0 = rd_data[6];
        rd_oe = 1'b1; rd_ce = 1'b1;
        step();
        rd_oe = 1'b0; rd_ce = 1'b0;
        check("R3 both strobes once", rd_data[6], !b0);
        rd_ce = 1'b1;
        step();
        rd_ce = 1'b0;
        check("R3 ce read", rd_data[6], b0);
        step(); step();
        check("R3 hold without read", rd_data[6], b0);
        while (busy) step();

        // R7: idle reads leave toggle unchanged
        saved = m_tog;
        repeat (5) begin rd_oe = 1'b1; rd_ce = 1'($urandom); step(); end
        rd_oe = 1'b0; rd_ce = 1'b0;
        busy_len = 8'd4; cmd_done = 1'b1;
        step();
        cmd_done = 1'b0;
        check("R7 toggle kept", rd_data[6], saved);
        while (busy) step();

        // R9 / R10: timeout then reset command
        tmo_inject = 1'b1;
        step();
        tmo_inject = 1'b0;
        check("R10 tmo idle ignored", busy, 0);
        busy_len = 8'd3; cmd_done = 1'b1;
        step();
        cmd_done = 1'b0;
        check("R10 no stale timeout", rd_data[5], 0);
        tmo_inject = 1'b1;
        step();
        tmo_inject = 1'b0;
        b0 = rd_data[6];
        repeat (30) step();
        check("R9 stays busy", busy, 1);
        check("R9 timeout flag", rd_data[5], 1);
        rd_oe = 1'b1;
        step();
        rd_oe = 1'b0;
        check("R9 still toggles", rd_data[6], !b0);
        rst_cmd = 1'b1;
        step();
        rst_cmd = 1'b0;
        check("R10 abort idle", busy, 0);
        check("R10 abort data", rd_data, array_data);
        busy_len = 8'd2; cmd_done = 1'b1;
        step();
        cmd_done = 1'b0;
        check("R10 toggle cleared", rd_data[6], 0);
        check("R10 timeout cleared", rd_data[5], 0);

        // random phase, compared cycle by cycle
        for (int i = 0; i < 4000; i++) begin
            cmd_done   = ($urandom % 6) == 0;
            op_erase   = 1'($urandom);
            tgt_prot   = ($urandom % 10) == 0;
            busy_len   = LEN_W'($urandom % 12);
            rd_oe      = 1'($urandom);
            rd_ce      = 1'($urandom);
            tmo_inject = ($urandom % 40) == 0;
            rst_cmd    = ($urandom % 50) == 0;
            step();
        end
        {cmd_done, rd_oe, rd_ce, tmo_inject} = '0;
        rst_cmd = 1'b1;
        step();
        rst_cmd = 1'b0;
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule